// File: doc/BRIEF.md
# Segmented Cartridge Bank-Switch Controller

This block maps an 8 KB cartridge ROM into the 4 KB cartridge window of a small 6502-family system with 13 address lines. The window is cut into four 1 KB regions picked by address bits A11:A10. The first three regions each show any one of eight 1 KB ROM pages, selected by a 3-bit page register per region. The last region always shows page 7, so the reset and interrupt vectors at the top of the address space stay in place whatever the other regions hold.

The page registers change on address alone. A valid access anywhere in one of three 8-byte hotspot ranges near the top of the window copies address bits A2:A0 into the register of the matching region. No data bus and no read/write direction reach the block, so reads and writes switch the same way. The block drives a ROM chip select and the 13-bit ROM address. The upper three bits come from the region lookup and the lower ten pass straight through from the CPU address.

Each bus cycle is presented as one clock cycle with `bus_valid` high. The outputs follow the current address within the same cycle. A register change lands on the clock edge that ends the hotspot access, so the new page is seen from the following access on.

Top module: `bsw_seg_ctrl`

## Requirements
- R1: `rom_cs` is high in a cycle exactly when `bus_valid` is high and address bit A12 is 1. Addresses with A12 = 0 never select the ROM.
- R2: While `rom_cs` is high, `rom_addr[9:0]` equals `bus_addr[9:0]`.
- R3: An access with A12 = 1 and A11:A10 = 3 always drives `rom_addr[12:10]` = 7, including accesses to the hotspots.
- R4: After a synchronous reset (`rst_n` low on a rising edge), regions 0, 1 and 2 show pages 4, 5 and 6 respectively. This holds again if reset is applied after pages were switched.
- R5: A valid access to 0x1FE0+k loads region 0 with page k (k = 0..7). 0x1FE8+k loads region 1 with k, and 0x1FF0+k loads region 2 with k.
- R6: A page register loaded by a hotspot access takes effect from the very next access. While `rom_cs` is high with A11:A10 = r (r < 3), `rom_addr[12:10]` equals the page currently held for region r.
- R7: No other access changes any page register. This covers 0x1FF8..0x1FFF, 0x1FDF and below, and aliases of the hotspot offsets with A12 = 0 such as 0x0FE0.
- R8: A cycle with `bus_valid` low changes no page register, even when the address lies on a hotspot.
- R9: While `rom_cs` is low, `rom_addr` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; one bus access per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | High when the cycle carries a CPU access |
| bus_addr | input | 13 | CPU address A12:A0 |
| rom_cs | output | 1 | ROM chip select, active high |
| rom_addr | output | 13 | ROM address: page in [12:10], offset in [9:0] |

## Verification
The assertions assume that `bus_valid` and `bus_addr` are steady around each rising clock edge and that each access lasts exactly one clock. They also assume that reset is held low for at least one rising edge before the first access. The bench drives every input on the falling edge, holds it for a full cycle and releases reset only after several edges, so every access is sampled once and in a settled state. Because the outputs are combinational in the current address, the bench reads them shortly after the falling-edge drive and before the next rising edge. It then updates its own page model only after that edge, matching the one-access delay of a switch.

// File: rtl/bsw_pkg.sv
// Package: shared widths, types and fixed constants of the segmented
// bank-switch controller. Assumes a 13-line CPU bus whose top bit marks
// the cartridge window, and 1 KB regions within it.
package bsw_pkg;
    localparam int ADDR_W     = 13;             // CPU address lines
    localparam int OFS_W      = 10;             // in-region offset bits (1 KB)
    localparam int SEL_W      = 2;              // region select bits
    localparam int PAGE_W     = 3;              // ROM page number bits
    localparam int NUM_SW     = 3;              // switchable regions
    localparam int NUM_REGION = 1 << SEL_W;     // regions in the window
    localparam int ROM_W      = PAGE_W + OFS_W; // ROM address width
    localparam int HOT_LO     = PAGE_W + SEL_W; // lowest bit of hotspot base match

    typedef logic [PAGE_W-1:0] page_t;
    typedef logic [SEL_W-1:0]  region_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [ROM_W-1:0]  rom_addr_t;

    localparam addr_t DEF_HOT_BASE   = 13'h1FE0; // first hotspot byte
    localparam page_t DEF_FIXED_PAGE = 3'd7;     // page of the top region
    localparam page_t DEF_RESET_BASE = 3'd4;     // reset page of region 0
endpackage

// File: rtl/bsw_hot_decode.sv
// Hotspot decoder: recognises a valid access inside the block of
// 8-byte hotspot groups starting at HOT_BASE. Group g (g < NUM_SW)
// targets region g, and the low address bits give the new page.
// Assumes HOT_BASE is aligned to the size of the whole group block.
module bsw_hot_decode
    import bsw_pkg::*;
#(
    parameter addr_t HOT_BASE = DEF_HOT_BASE
) (
    input  logic    acc_valid,
    input  addr_t   acc_addr,
    output logic    hot_hit,
    output region_t hot_region,
    output page_t   hot_page
);
    localparam int TAG_W = ADDR_W - HOT_LO;
    localparam logic [TAG_W-1:0] HOT_TAG = HOT_BASE[ADDR_W-1:HOT_LO];

    logic tag_match;
    logic group_ok;

    // Split the address into tag, group index and page value.
    always_comb begin
        tag_match  = (acc_addr[ADDR_W-1:HOT_LO] == HOT_TAG);
        hot_region = acc_addr[PAGE_W +: SEL_W];
        hot_page   = acc_addr[PAGE_W-1:0];
        group_ok   = (int'(hot_region) < NUM_SW);
        hot_hit    = acc_valid && tag_match && group_ok;
    end
endmodule

// File: rtl/bsw_bank_regs.sv
// Page register file: one PAGE_W-bit register per switchable region.
// Loads the addressed register on a hotspot hit and returns region i
// to page RESET_BASE+i on synchronous reset.
module bsw_bank_regs
    import bsw_pkg::*;
#(
    parameter page_t RESET_BASE = DEF_RESET_BASE
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  region_t                        wr_region,
    input  page_t                          wr_page,
    output logic [NUM_SW-1:0][PAGE_W-1:0]  pages
);
    for (genvar i = 0; i < NUM_SW; i++) begin : g_reg
        localparam page_t RST_VAL = page_t'(int'(RESET_BASE) + i);
        logic sel;

        // Decode whether this register is the write target.
        always_comb sel = wr_en && (int'(wr_region) == i);

        // Hold or load the page of region i.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pages[i] <= RST_VAL;
            else if (sel)
                pages[i] <= wr_page;
        end
    end
endmodule

// File: rtl/bsw_region_map.sv
// Region lookup: selects the page for the region addressed by A11:A10,
// forcing FIXED_PAGE for regions without a register, and builds the
// ROM chip select and address. Output is zero when the ROM is idle.
module bsw_region_map
    import bsw_pkg::*;
#(
    parameter page_t FIXED_PAGE = DEF_FIXED_PAGE
) (
    input  logic                           acc_valid,
    input  addr_t                          acc_addr,
    input  logic [NUM_SW-1:0][PAGE_W-1:0]  pages,
    output logic                           cs,
    output rom_addr_t                      rom_addr
);
    region_t region;
    page_t   page_sel;

    // Pick the page of the addressed region, default to the fixed page.
    always_comb begin
        region   = acc_addr[OFS_W +: SEL_W];
        page_sel = FIXED_PAGE;
        for (int i = 0; i < NUM_SW; i++) begin
            if (int'(region) == i)
                page_sel = pages[i];
        end
    end

    // Drive the select and the ROM address, zero while not selected.
    always_comb begin
        cs       = acc_valid && acc_addr[ADDR_W-1];
        rom_addr = cs ? {page_sel, acc_addr[OFS_W-1:0]} : '0;
    end
endmodule

// File: rtl/bsw_seg_ctrl.sv
// Top of the segmented bank-switch controller. Ties the hotspot
// decoder, the page register file and the region lookup together.
// Assumes one bus access per clock, qualified by bus_valid.
module bsw_seg_ctrl
    import bsw_pkg::*;
#(
    parameter addr_t HOT_BASE   = DEF_HOT_BASE,
    parameter page_t FIXED_PAGE = DEF_FIXED_PAGE,
    parameter page_t RESET_BASE = DEF_RESET_BASE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic [12:0]       bus_addr,
    output logic              rom_cs,
    output logic [12:0]       rom_addr
);
    logic                          hot_hit;
    region_t                       hot_region;
    page_t                         hot_page;
    logic [NUM_SW-1:0][PAGE_W-1:0] bank_q;

    bsw_hot_decode #(.HOT_BASE(HOT_BASE)) u_dec (
        .acc_valid  (bus_valid),
        .acc_addr   (bus_addr),
        .hot_hit    (hot_hit),
        .hot_region (hot_region),
        .hot_page   (hot_page)
    );

    bsw_bank_regs #(.RESET_BASE(RESET_BASE)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (hot_hit),
        .wr_region (hot_region),
        .wr_page   (hot_page),
        .pages     (bank_q)
    );

    bsw_region_map #(.FIXED_PAGE(FIXED_PAGE)) u_map (
        .acc_valid (bus_valid),
        .acc_addr  (bus_addr),
        .pages     (bank_q),
        .cs        (rom_cs),
        .rom_addr  (rom_addr)
    );
endmodule

// File: rtl/bsw_seg_ctrl_chk.sv
// Checker for bsw_seg_ctrl: relates the bus inputs, the page registers
// and the ROM outputs over time. Assumes the default hotspot base,
// fixed page and reset pages from bsw_pkg.
module bsw_seg_ctrl_chk
    import bsw_pkg::*;
(
    input logic                          clk,
    input logic                          rst_n,
    input logic                          bus_valid,
    input logic [12:0]                   bus_addr,
    input logic                          rom_cs,
    input logic [12:0]                   rom_addr,
    input logic [NUM_SW-1:0][PAGE_W-1:0] bank_q
);
    logic    hot_now;
    region_t grp;
    region_t reg_sel;

    // Independent view of which region, if any, this access retargets.
    always_comb begin
        grp     = bus_addr[4:3];
        reg_sel = bus_addr[11:10];
        hot_now = bus_valid && (bus_addr[12:5] == DEF_HOT_BASE[12:5]) && (grp != 2'd3);
    end

    // R1: nothing outside the cartridge window, nothing without a valid cycle.
    a_r1_cs_window: assert property (@(posedge clk) disable iff (!rst_n)
        rom_cs |-> (bus_valid && bus_addr[12]));
    a_r1_cs_present: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_addr[12]) |-> rom_cs);

    // R2: offset bits pass through.
    a_r2_offset: assert property (@(posedge clk) disable iff (!rst_n)
        rom_cs |-> (rom_addr[9:0] == bus_addr[9:0]));

    // R3: top region is pinned.
    a_r3_fixed_top: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_cs && reg_sel == 2'd3) |-> (rom_addr[12:10] == DEF_FIXED_PAGE));

    // R9: idle ROM address.
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_cs |-> (rom_addr == '0));

    for (genvar i = 0; i < NUM_SW; i++) begin : g_region
        // R4: reset pages.
        a_r4_reset_page: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> (bank_q[i] == page_t'(int'(DEF_RESET_BASE) + i)));
        // R5: hotspot load.
        a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
            (hot_now && int'(grp) == i) |=> (bank_q[i] == $past(bus_addr[2:0])));
        // R7 / R8: hold without a matching hotspot access.
        a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(hot_now && int'(grp) == i) |=> $stable(bank_q[i]));
        // R6: output page follows the held register.
        a_r6_map: assert property (@(posedge clk) disable iff (!rst_n)
            (rom_cs && int'(reg_sel) == i) |-> (rom_addr[12:10] == bank_q[i]));
    end
endmodule

bind bsw_seg_ctrl bsw_seg_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_addr  (bus_addr),
    .rom_cs    (rom_cs),
    .rom_addr  (rom_addr),
    .bank_q    (bank_q)
);

// File: tb/bsw_seg_ctrl_tb.sv
// Directed bench for bsw_seg_ctrl: a bench-side page model predicts the
// chip select and ROM address of every access.
module bsw_seg_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_valid;
    logic [12:0] bus_addr;
    logic        rom_cs;
    logic [12:0] rom_addr;

    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;
    logic [2:0] model [3];

    always #4 clk = ~clk;   // 125 MHz

    bsw_seg_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_addr  (bus_addr),
        .rom_cs    (rom_cs),
        .rom_addr  (rom_addr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One bus cycle: drive, check the outputs, then advance the model.
    task automatic acc(input logic v, input logic [12:0] a, input string req);
        logic        e_cs;
        logic [2:0]  pg;
        logic [12:0] e_addr;
        @(negedge clk);
        bus_valid = v;
        bus_addr  = a;
        #1;
        e_cs   = v && a[12];
        pg     = (a[11:10] == 2'd3) ? 3'd7 : model[a[11:10]];
        e_addr = e_cs ? {pg, a[9:0]} : 13'h0;
        chk({req, " cs"}, 32'(rom_cs), 32'(e_cs));
        chk({req, " addr"}, 32'(rom_addr), 32'(e_addr));
        @(posedge clk);
        if (rst_n && v && a[12:5] == 8'hFF && a[4:3] != 2'd3)
            model[a[4:3]] = a[2:0];
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_valid = 1'b0; bus_addr = '0;
        repeat (3) @(posedge clk);
        model[0] = 3'd4; model[1] = 3'd5; model[2] = 3'd6;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R4, R1, R3: defaults visible in every region after reset.
    task automatic t_reset_defaults();
        do_reset();
        acc(1'b1, 13'h1000, "R4 region0");
        acc(1'b1, 13'h1400, "R4 region1");
        acc(1'b1, 13'h1800, "R4 region2");
        acc(1'b1, 13'h1C00, "R3 region3");
        acc(1'b1, 13'h0123, "R1 low half");
    endtask

    // R2: offsets across each region.
    task automatic t_offsets();
        acc(1'b1, 13'h13FF, "R2 offset");
        acc(1'b1, 13'h1555, "R2 offset");
        acc(1'b1, 13'h1AAA, "R2 offset");
        acc(1'b1, 13'h1FFF, "R2 offset");
    endtask

    // R5, R6: every page into every region, read back on the next access.
    task automatic t_switch_each();
        for (int r = 0; r < 3; r++) begin
            for (int k = 0; k < 8; k++) begin
                acc(1'b1, 13'(13'h1FE0 + r * 8 + k), "R5 hotspot");
                acc(1'b1, 13'(13'h1000 + r * 13'h400 + k * 7), "R6 next access");
            end
        end
    endtask

    // R7: look-alike addresses leave all pages untouched.
    task automatic t_non_hot();
        acc(1'b1, 13'h1FE2, "R5 set r0");
        acc(1'b1, 13'h1FEB, "R5 set r1");
        acc(1'b1, 13'h1FF1, "R5 set r2");
        acc(1'b1, 13'h1FF8, "R7 group3");
        acc(1'b1, 13'h1FFD, "R7 group3");
        acc(1'b1, 13'h1FDF, "R7 below");
        acc(1'b1, 13'h0FE5, "R7 alias");
        acc(1'b1, 13'h0FF3, "R7 alias");
        acc(1'b1, 13'h1010, "R7 r0 kept");
        acc(1'b1, 13'h1410, "R7 r1 kept");
        acc(1'b1, 13'h1810, "R7 r2 kept");
    endtask

    // R8, R9: idle cycles on hotspots do nothing and drive zero.
    task automatic t_idle();
        acc(1'b0, 13'h1FE7, "R8 idle");
        acc(1'b0, 13'h1FEE, "R9 idle");
        acc(1'b0, 13'h1FF4, "R9 idle");
        acc(1'b1, 13'h1001, "R8 r0 kept");
        acc(1'b1, 13'h1402, "R8 r1 kept");
        acc(1'b1, 13'h1803, "R8 r2 kept");
    endtask

    // R3: top region stays pinned across switches.
    task automatic t_fixed_top();
        acc(1'b1, 13'h1FE0, "R3 hot");
        acc(1'b1, 13'h1FFC, "R3 vector");
        acc(1'b1, 13'h1FF7, "R3 hot");
        acc(1'b1, 13'h1C42, "R3 top");
    endtask

    // R4: reset after switching restores defaults.
    task automatic t_reset_again();
        acc(1'b1, 13'h1FE1, "R5 pre reset");
        do_reset();
        acc(1'b1, 13'h1020, "R4 r0 again");
        acc(1'b1, 13'h1420, "R4 r1 again");
        acc(1'b1, 13'h1820, "R4 r2 again");
    endtask

    initial begin
        rst_n = 1'b0; bus_valid = 1'b0; bus_addr = '0;
        model[0] = 3'd4; model[1] = 3'd5; model[2] = 3'd6;
        t_reset_defaults();
        t_offsets();
        t_switch_each();
        t_non_hot();
        t_idle();
        t_fixed_top();
        t_reset_again();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule